// File: doc/BRIEF.md
# Split Instruction/Data Page Mapper

This block turns a 16-bit logical address into a 22-bit physical address using two small register-held page tables. One table serves instruction fetches and the other serves data accesses. The top three address bits pick one of eight entries in the selected table. The entry's 9-bit frame number is placed above the 13-bit page offset, which passes through unchanged. Each page is 8 KB, and the physical space is 4 MB.

Each entry holds a frame number, a valid flag and a store-permission flag. Software loads entries through a one-cycle write port that names the table, the entry and the new contents.

Lookups are single-cycle requests. The physical address and the fault flag appear on registered outputs one clock after the request. A request faults when its entry is not valid. It also faults when it is a data store through an entry that does not permit stores.

Top module: `page_mapper`

## Requirements
- R1: After reset every entry of both tables is invalid and `rsp_valid` is low, so any request made before the first table write faults.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high, and low otherwise; back-to-back requests each give their own response.
- R3: The page index is `req_addr[15:13]`, and on a non-faulting response `rsp_paddr[12:0]` equals `req_addr[12:0]`.
- R4: On a non-faulting response `rsp_paddr[21:13]` equals the frame number held in the selected entry.
- R5: `req_data`=0 selects the instruction table and `req_data`=1 selects the data table; an entry written in one table has no effect on lookups in the other.
- R6: A table write (`cfg_we`=1, `cfg_sel_data`=0 instruction / 1 data, index `cfg_idx`) replaces frame, valid flag and store flag in one cycle. Requests from the next cycle on see the new contents, and a request in the same cycle as the write sees the old contents.
- R7: A request whose selected entry has its valid flag clear returns `rsp_fault`=1.
- R8: A data request with `req_write`=1 through a valid entry whose store flag is clear faults; a data read through the same entry does not.
- R9: For instruction requests `req_write` and the store flag are ignored: a valid instruction entry never faults.
- R10: When `rsp_fault` is 1, `rsp_paddr` is zero.
- R11: While `rsp_valid` is low, `rsp_fault` is 0 and `rsp_paddr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_sel_data | input | 1 | Table to write: 0 instruction, 1 data |
| cfg_idx | input | 3 | Entry index to write |
| cfg_frame | input | 9 | Frame number to store |
| cfg_valid | input | 1 | Valid flag to store |
| cfg_wr_ok | input | 1 | Store-permission flag to store |
| req_valid | input | 1 | Translation request strobe |
| req_data | input | 1 | Request kind: 0 instruction fetch, 1 data access |
| req_write | input | 1 | Data access is a store |
| req_addr | input | 16 | Logical address |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_paddr | output | 22 | Physical address, zero on fault or when idle |
| rsp_fault | output | 1 | Access fault |

## Verification
The assertions assume that reset is held low at the first clock edge, so the table registers start from a known state. They also assume that every input is at a defined level at each rising edge. The write-landing check further assumes that `cfg_idx` is never out of range, which a 3-bit index with eight entries guarantees.

The bench meets these assumptions by driving every input from the falling edge and holding reset low for several cycles before any traffic. It never leaves a request or write strobe undriven. It covers same-cycle write-and-lookup collisions and back-to-back requests, so the ordering rules are tested at their edges.

// File: rtl/pmap_pkg.sv
// Shared widths and entry type for the split page mapper.
// Assumes the logical address width equals index bits plus offset bits.
package pmap_pkg;
    parameter int PM_LA_W    = 16;                      // logical address width
    parameter int PM_OFF_W   = 13;                      // page offset width (8 KB)
    parameter int PM_FRAME_W = 9;                       // frame number width
    parameter int PM_IDX_W   = PM_LA_W - PM_OFF_W;      // page index width
    parameter int PM_ENTRIES = 1 << PM_IDX_W;           // entries per table
    parameter int PM_PA_W    = PM_FRAME_W + PM_OFF_W;   // physical address width
    parameter int PM_TABLES  = 2;                       // instruction and data

    typedef struct packed {
        logic [PM_FRAME_W-1:0] frame;
        logic                  valid;
        logic                  wr_ok;
    } pm_entry_t;
endpackage

// File: rtl/pmap_table.sv
// One page table held in flops: a single write port and one combinational
// read port. Assumes wr_idx and rd_idx stay below ENTRIES.
module pmap_table
    import pmap_pkg::*;
#(
    parameter int ENTRIES = PM_ENTRIES,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  logic [IW-1:0] wr_idx,
    input  pm_entry_t wr_ent,
    input  logic [IW-1:0] rd_idx,
    output pm_entry_t rd_ent
);
    pm_entry_t           tbl [ENTRIES];
    logic [ENTRIES-1:0]  valid_vec;

    // Entry storage: clear on reset, replace one entry per write.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tbl[e] <= '0;
            end else if (wr_en && (wr_idx == IW'(e))) begin
                tbl[e] <= wr_ent;
            end
        end
        assign valid_vec[e] = tbl[e].valid;
    end

    // Read port: returns the entry selected by the page index.
    assign rd_ent = tbl[rd_idx];

    // R1: no entry may remain valid through reset.
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (valid_vec == '0));

    // R6: a write is fully in place on the following cycle.
    assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tbl[$past(wr_idx)] == $past(wr_ent)));
endmodule

// File: rtl/pmap_xlate.sv
// Combinational lookup stage: picks the table by request kind, checks the
// entry flags and forms {frame, offset}. Assumes both entries are already
// read at the request's page index.
module pmap_xlate
    import pmap_pkg::*;
(
    input  logic                req_data,
    input  logic                req_write,
    input  logic [PM_LA_W-1:0]  req_addr,
    input  pm_entry_t           ins_ent,
    input  pm_entry_t           dat_ent,
    output logic                fault,
    output logic [PM_PA_W-1:0]  paddr
);
    pm_entry_t sel;
    logic      store_block;

    // Table choice and permission check.
    always_comb begin
        sel         = req_data ? dat_ent : ins_ent;
        store_block = req_data && req_write && !sel.wr_ok;
        fault       = !sel.valid || store_block;
    end

    // Address assembly: frame on top, offset passes through; zero on fault.
    always_comb begin
        if (fault) paddr = '0;
        else       paddr = {sel.frame, req_addr[PM_OFF_W-1:0]};
    end
endmodule

// File: rtl/page_mapper.sv
// Top of the split page mapper: two eight-entry tables, a lookup stage and
// a response register. Result is available one cycle after the request.
// Assumes a synchronous active-low reset held for at least one edge.
module page_mapper
    import pmap_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic                  cfg_sel_data,
    input  logic [PM_IDX_W-1:0]   cfg_idx,
    input  logic [PM_FRAME_W-1:0] cfg_frame,
    input  logic                  cfg_valid,
    input  logic                  cfg_wr_ok,
    input  logic                  req_valid,
    input  logic                  req_data,
    input  logic                  req_write,
    input  logic [PM_LA_W-1:0]    req_addr,
    output logic                  rsp_valid,
    output logic [PM_PA_W-1:0]    rsp_paddr,
    output logic                  rsp_fault
);
    pm_entry_t             new_ent;
    pm_entry_t             rd_ent [PM_TABLES];
    logic [PM_IDX_W-1:0]   page;
    logic                  x_fault;
    logic [PM_PA_W-1:0]    x_paddr;

    assign new_ent = '{frame: cfg_frame, valid: cfg_valid, wr_ok: cfg_wr_ok};
    assign page    = req_addr[PM_LA_W-1:PM_OFF_W];

    // Table 0 serves fetches, table 1 serves data; write steered by select.
    for (genvar t = 0; t < PM_TABLES; t++) begin : g_tbl
        pmap_table #(.ENTRIES(PM_ENTRIES)) u_tbl (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (cfg_we && (cfg_sel_data == t[0])),
            .wr_idx (cfg_idx),
            .wr_ent (new_ent),
            .rd_idx (page),
            .rd_ent (rd_ent[t])
        );
    end

    pmap_xlate u_xlate (
        .req_data  (req_data),
        .req_write (req_write),
        .req_addr  (req_addr),
        .ins_ent   (rd_ent[0]),
        .dat_ent   (rd_ent[1]),
        .fault     (x_fault),
        .paddr     (x_paddr)
    );

    // Response register: captures the lookup, stays quiet when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_fault <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_paddr <= req_valid ? x_paddr : '0;
            rsp_fault <= req_valid && x_fault;
        end
    end

    // R2: one response per request, one cycle later.
    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R3: offset survives translation whenever no fault is raised.
    assert_offset_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_fault || (rsp_paddr[PM_OFF_W-1:0] == $past(req_addr[PM_OFF_W-1:0]))));

    // R10: faulting responses carry no address.
    assert_fault_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_paddr == '0));

    // R11: idle outputs are quiet.
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_fault && (rsp_paddr == '0)));
endmodule

// File: tb/sim_page_mapper.sv
// Directed bench for page_mapper: one task per scenario.
module sim_page_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_sel_data = 1'b0, cfg_valid = 1'b0, cfg_wr_ok = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [8:0]  cfg_frame = '0;
    logic        req_valid = 1'b0, req_data = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic        rsp_valid, rsp_fault;
    logic [21:0] rsp_paddr;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;   // 250 MHz

    page_mapper u0 (.*);

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic put_entry(input bit dsel, input int idx, input int frame, input bit v, input bit w);
        @(negedge clk);
        cfg_we = 1; cfg_sel_data = dsel; cfg_idx = 3'(idx);
        cfg_frame = 9'(frame); cfg_valid = v; cfg_wr_ok = w;
        @(negedge clk);
        cfg_we = 0;
    endtask

    // Issue one request and check the response one cycle later.
    task automatic lookup(input string tag, input bit d, input bit w, input logic [15:0] a,
                          input bit exp_fault, input int exp_frame);
        logic [21:0] exp_pa;
        exp_pa = exp_fault ? 22'h0 : {9'(exp_frame), a[12:0]};
        @(negedge clk);
        req_valid = 1; req_data = d; req_write = w; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
        chk({tag, " fault"}, 32'(rsp_fault), 32'(exp_fault));
        chk({tag, " paddr"}, 32'(rsp_paddr), 32'(exp_pa));
    endtask

    task automatic t_reset;
        chk("R1 rsp_valid after reset", 32'(rsp_valid), 0);
        chk("R11 idle paddr", 32'(rsp_paddr), 0);
        chk("R11 idle fault", 32'(rsp_fault), 0);
        lookup("R1 R7 fetch lowest", 0, 0, 16'h0000, 1, 0);
        lookup("R1 R7 data highest", 1, 0, 16'hFFFF, 1, 0);
    endtask

    task automatic t_map;
        put_entry(0, 2, 9'h1A5, 1, 0);
        lookup("R3 R4 fetch page2", 0, 0, 16'h4123, 0, 9'h1A5);
        put_entry(0, 7, 9'h1FF, 1, 0);
        lookup("R3 R4 top page max offset", 0, 0, 16'hFFFF, 0, 9'h1FF);
        put_entry(0, 0, 9'h001, 1, 1);
        lookup("R3 R4 page0 offset0", 0, 0, 16'h0000, 0, 9'h001);
    endtask

    task automatic t_split;
        lookup("R5 data table untouched", 1, 0, 16'h4123, 1, 0);
        put_entry(1, 2, 9'h003, 1, 1);
        lookup("R5 data page2", 1, 0, 16'h5ABC, 0, 9'h003);
        lookup("R5 fetch page2 unchanged", 0, 0, 16'h5ABC, 0, 9'h1A5);
        lookup("R5 R8 data store allowed", 1, 1, 16'h4000, 0, 9'h003);
    endtask

    task automatic t_protect;
        put_entry(1, 5, 9'h077, 1, 0);
        lookup("R8 data read readonly", 1, 0, 16'hA010, 0, 9'h077);
        lookup("R8 R10 data store blocked", 1, 1, 16'hA010, 1, 0);
        lookup("R9 fetch ignores write", 0, 1, 16'h4555, 0, 9'h1A5);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        cfg_we = 1; cfg_sel_data = 0; cfg_idx = 3'd4; cfg_frame = 9'h0C0;
        cfg_valid = 1; cfg_wr_ok = 0;
        req_valid = 1; req_data = 0; req_write = 0; req_addr = 16'h8004;
        @(negedge clk);
        cfg_we = 0; req_valid = 0;
        chk("R6 same-cycle sees old", 32'(rsp_fault), 1);
        lookup("R6 next cycle sees new", 0, 0, 16'h8004, 0, 9'h0C0);
        put_entry(0, 2, 9'h1A5, 0, 0);
        lookup("R6 R7 invalidated entry", 0, 0, 16'h4123, 1, 0);
    endtask

    task automatic t_b2b;
        @(negedge clk);
        req_valid = 1; req_data = 1; req_write = 0; req_addr = 16'h4001;
        @(negedge clk);
        chk("R2 b2b first valid", 32'(rsp_valid), 1);
        chk("R2 b2b first paddr", 32'(rsp_paddr), 32'({9'h003, 13'h0001}));
        req_data = 0; req_addr = 16'hE002;
        @(negedge clk);
        req_valid = 0;
        chk("R2 b2b second valid", 32'(rsp_valid), 1);
        chk("R2 b2b second paddr", 32'(rsp_paddr), 32'({9'h1FF, 13'h0002}));
        @(negedge clk);
        chk("R2 idle after b2b", 32'(rsp_valid), 0);
        chk("R11 idle paddr zero", 32'(rsp_paddr), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        t_map;
        t_split;
        t_protect;
        t_same_cycle;
        t_b2b;
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: actual=hung expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule